// File: doc/BRIEF.md
# Display memory access controller with width-dependent write rules

This block sits in front of three display storage arrays: a video RAM made of three equal banks, a 1 KiB palette RAM and a 1 KiB object-attribute RAM. Each single-cycle request names a region, a byte address, an access size, a write flag and write data. Reads and writes of 8, 16 or 32 bits are accepted. The block mirrors the address into the selected array and aligns it to the access size. Halfword and word writes are stored little-endian.

Byte writes follow rules that depend on the region. In the palette, a byte write is widened to a halfword that carries the byte in both halves. Byte writes to the object-attribute RAM are discarded. Video RAM widens byte writes in the same way as the palette, but only below a boundary that depends on the background mode given at `bg_mode_i`. Read data comes back one cycle after the request, together with a valid strobe. The first palette halfword is also driven continuously as the backdrop colour.

Every array is cleared by reset. The geometry is set by `VB_AW`, which is the byte-address width of one video bank, and `SM_AW`, which is the byte-address width of the two small arrays. The default `VB_AW`=10 gives a scaled 3 KiB video RAM, and `VB_AW`=15 gives the full 96 KiB. The numbers below use the defaults, with the full-size value in brackets. The small arrays must satisfy `VB_AW`+2 > `SM_AW`.

Top module: `dmw_ctrl`

## Requirements
- R1: While reset is held and after it is released, `rvalid_o` is 0 and `backdrop_o` is 0, and every location in every region reads as 0 until it is written.
- R2: Video RAM offsets are formed from the low 12 [17] address bits. A value below 0xC00 [0x18000] is used unchanged. Any other value maps to 0x800 [0x10000] plus the low 10 [15] address bits, so the third bank repeats.
- R3: Palette (region 1) and object-attribute RAM (region 2) use the low 10 address bits, so each array repeats across the address space.
- R4: The size encoding is 0 for 8 bits, 1 for 16 bits, and 2 or 3 for 32 bits. A halfword access clears address bit 0 and a word access clears bits 1:0. Halfword and word writes store their data little-endian at the aligned offset, in all three regions.
- R5: An 8-bit write to object-attribute RAM changes no location.
- R6: An 8-bit palette write clears address bit 0 and stores the byte into both bytes of that halfword.
- R7: An 8-bit video RAM write (region 0) that is not blocked clears bit 0 of the mirrored offset and stores the byte into both bytes of that halfword.
- R8: In background modes 0, 1 and 2, an 8-bit video RAM write whose mirrored offset is 0x800 [0x10000] or higher is dropped.
- R9: In background modes 3 to 7, an 8-bit video RAM write whose mirrored offset is 0xA00 [0x14000] or higher is dropped. Offsets below that boundary are written.
- R10: A read request (`we_i`=0) raises `rvalid_o` for exactly one cycle, on the cycle after the request. `rdata_o` then holds the little-endian value, zero-extended, taken from the mirrored and aligned offset. Region 3 is unmapped: reads return 0 and writes are dropped. No write and no idle cycle raises `rvalid_o`.
- R11: `backdrop_o` equals palette bytes 1:0 and follows any write to them from the cycle after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; clears all arrays |
| req_i | input | 1 | Request valid for this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| region_i | input | 2 | 0 video RAM, 1 palette, 2 object attributes, 3 unmapped |
| size_i | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| addr_i | input | VB_AW+2 | Byte address within the region window |
| wdata_i | input | 32 | Write data, right-aligned |
| bg_mode_i | input | 3 | Current background mode |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 32 | Read data, zero-extended |
| backdrop_o | output | 16 | First palette halfword |

## Verification
Every write goes through a behavioural byte model that encodes the rules, and every read is compared against that model. Video RAM accesses are made through aliased addresses in the first two banks, in the repeated third bank, and at offsets above the 128 KiB [scaled] window. This separates the real mirror from one that is simply truncated. Byte writes are placed on each side of both blocking boundaries, under modes from the text group and from the bitmap group, and also through a mirrored alias. Each boundary is therefore confirmed both on its mode selection and on its comparison. Pre-filled words show that dropped byte writes and object-attribute byte writes leave their neighbours untouched, and odd-address byte writes show the halfword duplication.

// File: rtl/dmw_pkg.sv
package dmw_pkg;
  typedef enum logic [1:0] {
    RG_VRAM = 2'd0,
    RG_PAL  = 2'd1,
    RG_OAM  = 2'd2,
    RG_NONE = 2'd3
  } region_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } size_e;

  typedef struct packed {
    logic [3:0]  be;
    logic [31:0] data;
  } wr_lane_t;
endpackage

// File: rtl/dmw_addr_map.sv
module dmw_addr_map
  import dmw_pkg::*;
#(
  parameter int unsigned VB_AW = 10,
  parameter int unsigned SM_AW = 10
) (
  input  region_e          region_i,
  input  size_e            size_i,
  input  logic [VB_AW+1:0] addr_i,
  input  logic [2:0]       bg_mode_i,
  output logic [VB_AW+1:0] off_o,
  output logic             wr_block_o
);
  localparam int unsigned WIN_W = VB_AW + 2;
  localparam logic [WIN_W-1:0] VRAM_END   = WIN_W'(3 << VB_AW);
  localparam logic [WIN_W-1:0] TEXT_LIMIT = WIN_W'(2 << VB_AW);
  localparam logic [WIN_W-1:0] BMP_LIMIT  = WIN_W'(5 << (VB_AW - 1));

  logic [WIN_W-1:0] vram_off, small_off, raw_off, limit;

  always_comb begin
    // third bank repeats over the top quarter of the window
    vram_off  = (addr_i < VRAM_END) ? addr_i : {2'b10, addr_i[VB_AW-1:0]};
    small_off = {{(WIN_W-SM_AW){1'b0}}, addr_i[SM_AW-1:0]};
    raw_off   = (region_i == RG_VRAM) ? vram_off : small_off;
    unique case (size_i)
      SZ_BYTE: off_o = raw_off;
      SZ_HALF: off_o = {raw_off[WIN_W-1:1], 1'b0};
      default: off_o = {raw_off[WIN_W-1:2], 2'b00};
    endcase
    limit = (bg_mode_i <= 3'd2) ? TEXT_LIMIT : BMP_LIMIT;
    wr_block_o = (region_i == RG_NONE) ||
                 ((size_i == SZ_BYTE) &&
                  ((region_i == RG_OAM) ||
                   ((region_i == RG_VRAM) && (vram_off >= limit))));
  end

  always_comb begin
    a_r2_vram_window: assert (vram_off < VRAM_END)
      else $error("mirrored video offset outside array");
  end
endmodule

// File: rtl/dmw_lane_gen.sv
module dmw_lane_gen
  import dmw_pkg::*;
(
  input  logic        we_i,
  input  logic        block_i,
  input  size_e       size_i,
  input  logic        lane_hi_i,
  input  logic [31:0] wdata_i,
  output wr_lane_t    lane_o
);
  always_comb begin
    unique case (size_i)
      SZ_BYTE: begin
        lane_o.data = {4{wdata_i[7:0]}};
        lane_o.be   = lane_hi_i ? 4'b1100 : 4'b0011;
      end
      SZ_HALF: begin
        lane_o.data = {2{wdata_i[15:0]}};
        lane_o.be   = lane_hi_i ? 4'b1100 : 4'b0011;
      end
      default: begin
        lane_o.data = wdata_i;
        lane_o.be   = 4'b1111;
      end
    endcase
    if (!we_i || block_i) lane_o.be = 4'b0000;
  end

  always_comb begin
    a_r6_halfword_pairs: assert ((lane_o.be[0] == lane_o.be[1]) && (lane_o.be[2] == lane_o.be[3]))
      else $error("byte enables split a halfword");
  end
endmodule

// File: rtl/dmw_ram.sv
module dmw_ram #(
  parameter int unsigned WORDS = 256,
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [3:0]       be_i,
  input  logic [31:0]      wd_i,
  output logic [31:0]      rdata_o
);
  logic [31:0] mem [WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
      rdata_o <= '0;
    end else begin
      for (int b = 0; b < 4; b++) begin
        if (be_i[b]) mem[idx_i][8*b +: 8] <= wd_i[8*b +: 8];
      end
      if (rd_i) rdata_o <= mem[idx_i];
    end
  end
endmodule

// File: rtl/dmw_ctrl.sv
module dmw_ctrl
  import dmw_pkg::*;
#(
  parameter int unsigned VB_AW = 10,
  parameter int unsigned SM_AW = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [1:0]       region_i,
  input  logic [1:0]       size_i,
  input  logic [VB_AW+1:0] addr_i,
  input  logic [31:0]      wdata_i,
  input  logic [2:0]       bg_mode_i,
  output logic             rvalid_o,
  output logic [31:0]      rdata_o,
  output logic [15:0]      backdrop_o
);
  localparam int unsigned WIN_W    = VB_AW + 2;
  localparam int unsigned VR_WORDS = 3 << (VB_AW - 2);
  localparam int unsigned SM_WORDS = 1 << (SM_AW - 2);
  localparam int unsigned NBANK    = 3;

  region_e          region;
  size_e            size;
  logic [WIN_W-1:0] off;
  logic             wr_block;
  wr_lane_t         lane;
  logic [3:0]       bank_be [NBANK];
  logic [31:0]      bank_rd [NBANK];

  assign region = region_e'(region_i);
  assign size   = size_e'(size_i);

  dmw_addr_map #(.VB_AW(VB_AW), .SM_AW(SM_AW)) i_addr_map (
    .region_i  (region),
    .size_i    (size),
    .addr_i    (addr_i),
    .bg_mode_i (bg_mode_i),
    .off_o     (off),
    .wr_block_o(wr_block)
  );

  dmw_lane_gen i_lane_gen (
    .we_i     (we_i),
    .block_i  (wr_block),
    .size_i   (size),
    .lane_hi_i(off[1]),
    .wdata_i  (wdata_i),
    .lane_o   (lane)
  );

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    localparam int unsigned W   = (g == 0) ? VR_WORDS : SM_WORDS;
    localparam int unsigned IDX = (g == 0) ? VB_AW : SM_AW - 2;
    logic sel;
    assign sel        = req_i && (region_i == 2'(g));
    assign bank_be[g] = sel ? lane.be : 4'b0000;
    dmw_ram #(.WORDS(W), .IDX_W(IDX)) i_ram (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .rd_i   (sel && !we_i),
      .idx_i  (off[IDX+1:2]),
      .be_i   (bank_be[g]),
      .wd_i   (lane.data),
      .rdata_o(bank_rd[g])
    );
  end

  // read return pipeline
  logic       rvalid_q;
  region_e    r_region;
  size_e      r_size;
  logic [1:0] r_lane;
  logic [31:0] r_word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      r_region <= RG_NONE;
      r_size   <= SZ_WORD;
      r_lane   <= 2'b00;
    end else begin
      rvalid_q <= req_i && !we_i;
      if (req_i && !we_i) begin
        r_region <= region;
        r_size   <= size;
        r_lane   <= off[1:0];
      end
    end
  end

  always_comb begin
    unique case (r_region)
      RG_VRAM: r_word = bank_rd[0];
      RG_PAL:  r_word = bank_rd[1];
      RG_OAM:  r_word = bank_rd[2];
      default: r_word = '0;
    endcase
    unique case (r_size)
      SZ_BYTE: rdata_o = {24'b0, r_word[8*r_lane +: 8]};
      SZ_HALF: rdata_o = {16'b0, r_lane[1] ? r_word[31:16] : r_word[15:0]};
      default: rdata_o = r_word;
    endcase
  end

  assign rvalid_o = rvalid_q;

  // shadow of palette halfword 0, avoids a second read port on the array
  logic [15:0] backdrop_q;
  logic        pal_w0;
  assign pal_w0 = (off[SM_AW-1:2] == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      backdrop_q <= '0;
    end else if (pal_w0) begin
      if (bank_be[1][0]) backdrop_q[7:0]  <= lane.data[7:0];
      if (bank_be[1][1]) backdrop_q[15:8] <= lane.data[15:8];
    end
  end

  assign backdrop_o = backdrop_q;

  a_r10_rvalid_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);
  a_r10_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_o);
  a_r11_backdrop_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i && region_i == 2'd1) |=> $stable(backdrop_o));
  a_r5_oam_byte_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && region_i == 2'd2 && size_i == 2'd0) |-> (bank_be[2] == 4'b0000));
  a_r10_unmapped_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && region_i == 2'd3) |-> ($countones({bank_be[0], bank_be[1], bank_be[2]}) == 0));
endmodule

// File: tb/test_dmw_ctrl.sv
module test_dmw_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [1:0]  region_i = 2'd0;
  logic [1:0]  size_i = 2'd0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [2:0]  bg_mode_i = 3'd0;
  logic        rvalid_o;
  logic [31:0] rdata_o;
  logic [15:0] backdrop_o;

  dmw_ctrl i_dmw_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .region_i(region_i), .size_i(size_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .bg_mode_i(bg_mode_i),
    .rvalid_o(rvalid_o), .rdata_o(rdata_o), .backdrop_o(backdrop_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  logic [7:0] vr_m [3072];
  logic [7:0] pl_m [1024];
  logic [7:0] oa_m [1024];

  function automatic int map_off(int r, int a, int sz);
    int o;
    if (r == 0) begin
      o = a & 'hFFF;
      if (o >= 'hC00) o = 'h800 + (a & 'h3FF);
    end else o = a & 'h3FF;
    if (sz == 1) o = o & ~1;
    else if (sz >= 2) o = o & ~3;
    return o;
  endfunction

  function automatic logic [7:0] mget(int r, int o);
    case (r)
      0: return vr_m[o];
      1: return pl_m[o];
      2: return oa_m[o];
      default: return 8'h00;
    endcase
  endfunction

  task automatic mset(int r, int o, logic [7:0] v);
    case (r)
      0: vr_m[o] = v;
      1: pl_m[o] = v;
      2: oa_m[o] = v;
      default: ;
    endcase
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic wr(int r, int a, int sz, logic [31:0] d, int mode);
    int o;
    o = map_off(r, a, sz);
    if (r != 3) begin
      if (sz == 0) begin
        if (!(r == 2 || (r == 0 && o >= ((mode <= 2) ? 'h800 : 'hA00)))) begin
          o = o & ~1;
          mset(r, o, d[7:0]);
          mset(r, o + 1, d[7:0]);
        end
      end else if (sz == 1) begin
        mset(r, o, d[7:0]);
        mset(r, o + 1, d[15:8]);
      end else begin
        for (int k = 0; k < 4; k++) mset(r, o + k, d[8*k +: 8]);
      end
    end
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b1; region_i = 2'(r); size_i = 2'(sz);
    addr_i = 12'(a); wdata_i = d; bg_mode_i = 3'(mode);
    @(negedge clk);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(int r, int a, int sz, string tag);
    int o;
    logic [31:0] e;
    o = map_off(r, a, sz);
    if (sz == 0) e = {24'b0, mget(r, o)};
    else if (sz == 1) e = {16'b0, mget(r, o + 1), mget(r, o)};
    else e = {mget(r, o + 3), mget(r, o + 2), mget(r, o + 1), mget(r, o)};
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(tag);
    req_i = 1'b1; we_i = 1'b0; region_i = 2'(r); size_i = 2'(sz); addr_i = 12'(a);
    @(negedge clk);
    req_i = 1'b0;
  endtask

  // monitor: pops the scoreboard whenever read data is returned
  always @(negedge clk) begin
    if (rst_ni && rvalid_o) begin
      if (exp_q.size() == 0) begin
        check("R10 unexpected rvalid", 32'h1, 32'h0);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, rdata_o, e);
      end
    end
  end

  bit done = 1'b0;
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 3072; i++) vr_m[i] = 8'h00;
    for (int i = 0; i < 1024; i++) begin pl_m[i] = 8'h00; oa_m[i] = 8'h00; end
    repeat (3) @(negedge clk);
    check("R1 rvalid in reset", {31'b0, rvalid_o}, 32'h0);
    check("R1 backdrop in reset", {16'b0, backdrop_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 rvalid after reset", {31'b0, rvalid_o}, 32'h0);
    rd(0, 'h100, 2, "R1 vram cleared");
    rd(1, 'h3FC, 2, "R1 pal cleared");
    rd(2, 'h000, 2, "R1 oam cleared");

    // palette word write, backdrop, mirrored reads
    wr(1, 'h000, 2, 32'h11223344, 0);
    check("R11 backdrop after word", {16'b0, backdrop_o}, 32'h00003344);
    rd(1, 'hC02, 1, "R3 pal mirror half");
    rd(1, 'h401, 0, "R10 pal byte lane");
    rd(1, 'h003, 1, "R4 half align read");

    // object attributes: half aligned write, byte writes ignored
    wr(2, 'h407, 1, 32'h0000BEEF, 0);
    rd(2, 'h004, 2, "R4 oam half aligned");
    wr(2, 'h010, 2, 32'h12345678, 0);
    wr(2, 'h011, 0, 32'h000000AA, 0);
    wr(2, 'h012, 0, 32'h000000AA, 3);
    rd(2, 'h810, 2, "R5 oam byte ignored");

    // palette byte duplication
    wr(1, 'h023, 0, 32'h0000005A, 0);
    rd(1, 'h020, 2, "R6 pal byte dup");
    wr(1, 'h000, 0, 32'h0000007E, 5);
    check("R11 backdrop after byte", {16'b0, backdrop_o}, 32'h00007E7E);
    wr(1, 'h002, 1, 32'h0000FFFF, 0);
    check("R11 backdrop untouched by upper half", {16'b0, backdrop_o}, 32'h00007E7E);

    // video mirroring
    wr(0, 'hC04, 2, 32'hCAFEF00D, 0);
    rd(0, 'h804, 2, "R2 third bank repeat");
    rd(0, 'hFF4 & 'hC04 | 'hC04, 2, "R2 repeat alias");
    wr(0, 'h5FC, 2, 32'hA5A55A5A, 0);
    rd(0, 'h5FC, 2, "R4 vram word");
    wr(0, 'h3FE, 2, 32'h01010101, 0);
    rd(0, 'h3FC, 2, "R4 word align write");

    // video byte rules
    wr(0, 'h7FF, 0, 32'h0000003C, 0);
    rd(0, 'h7FC, 2, "R7 vram byte below text limit");
    wr(0, 'h800, 2, 32'h01020304, 0);
    wr(0, 'h801, 0, 32'h000000EE, 2);
    rd(0, 'h800, 2, "R8 text mode drop");
    wr(0, 'hC01, 0, 32'h000000EE, 1);
    rd(0, 'h800, 2, "R8 text mode drop via mirror");
    wr(0, 'h801, 0, 32'h00000077, 3);
    rd(0, 'h800, 2, "R9 bitmap mode accept");
    wr(0, 'hC03, 0, 32'h00000066, 4);
    rd(0, 'h800, 2, "R9 bitmap accept via mirror");
    wr(0, 'h9FC, 2, 32'h55667788, 0);
    wr(0, 'h9FF, 0, 32'h00000099, 7);
    rd(0, 'h9FC, 2, "R9 just below bitmap limit");
    wr(0, 'hA00, 2, 32'hDEADBEEF, 0);
    wr(0, 'hA01, 0, 32'h00000011, 3);
    wr(0, 'hA02, 0, 32'h00000022, 1);
    rd(0, 'hA00, 2, "R9 bitmap limit drop");
    rd(0, 'h1A01, 0, "R10 vram byte read");

    // unmapped region
    wr(3, 'h000, 2, 32'hFFFFFFFF, 0);
    rd(3, 'h000, 2, "R10 unmapped read zero");
    rd(0, 'h000, 2, "R10 unmapped write dropped");
    rd(1, 'h000, 1, "R11 pal half0 matches backdrop");

    repeat (4) @(negedge clk);
    check("R10 all reads returned", exp_q.size(), 32'h0);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule